// File: doc/BRIEF.md
# I2C Channel-Select Controller for a Four-Way Bus Switch

This block is the digital control of a four-way downstream bus switch. It is an I2C target. It samples SCL and SDA with a fast system clock and recognises START and STOP conditions. It answers one 7-bit address, `1110_0S1S0`, where S1 and S0 come from two strap inputs. A write transfer loads a channel selection, and that selection reaches the four channel-enable outputs only when the bus shows a STOP. Connections are therefore made while every line sits idle high.

A read transfer returns one status byte. The low nibble is the channel selection currently applied. The high nibble shows which per-channel interrupt inputs are asserted at that moment. The block models its open-drain SDA driver as an output enable: `sda_oe` high means SDA is pulled low. An active-low reset input and the power-on reset both return the block to a cleared, idle state.

Top module: `i2csw_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `chan_en` is 0000 and `sda_oe` is low. The bus logic waits for a START.
- R2: The block acknowledges an address byte whose upper seven bits equal `11100` followed by `strap_a[1]` and `strap_a[0]`. It acknowledges by driving `sda_oe` high through the ninth clock. The eighth bit is 1 for a read and 0 for a write.
- R3: An address that does not match gets no acknowledge. Every later byte up to the next START is also left unacknowledged and has no effect on `chan_en`.
- R4: Each data byte of a matched write transfer is acknowledged. Its bits 3:0 are held pending, and `chan_en` does not change before a STOP.
- R5: At a STOP that ends a write transfer, the pending bits 3:0 appear on `chan_en`: bit n enables channel n, and any combination is allowed. Bits 7:4 of the written byte have no effect.
- R6: When several data bytes arrive in one write transfer, only the last one is applied at the STOP.
- R7: Every byte of a matched read transfer is sent MSB first. Its bits 3:0 are the applied `chan_en`, and each of its bits 7:4 is the inverse of `irq_n[3:0]`, so a low interrupt input reads as 1.
- R8: `sda_oe` rises only while SCL is low. It never changes while SCL is high, except to release.
- R9: A master NACK after a read byte ends the read. `sda_oe` stays low until the next START.
- R10: A START clears any pending selection and restarts address reception. This also holds for a repeated START in the middle of a byte. A selection that is not followed by a STOP is never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, also used as power-on reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_a | input | 2 | Strap pins giving address bits 1:0 |
| irq_n | input | 4 | Active-low interrupt input per channel |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain model) |
| chan_en | output | 4 | Channel enables applied to the switch |

## Verification
The bench builds the block with its default parameters: two synchronizer stages and the fixed upper address `11100`. With four channels, every selection value and every interrupt pattern can be swept in full. Every strap setting is paired with every candidate address, so the acknowledge and no-acknowledge decisions are covered in all sixteen combinations. The bench also exercises repeated START before and inside a data byte, multi-byte writes and reads, and a reset in the middle of a transfer.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;

  localparam int NCH    = 4;
  localparam int BYTE_W = 8;
  localparam int HI_W   = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK,
    ST_RDAT, ST_RACK, ST_RNXT, ST_SKIP
  } eng_st_t;

  // True when the received 7-bit address equals fixed high part plus straps
  function automatic logic addr_hit(input logic [6:0] rx_addr,
                                    input logic [HI_W-1:0] hi,
                                    input logic [1:0] strap);
    return rx_addr == {hi, strap};
  endfunction

  // Status byte: asserted interrupts on top, applied selection below
  function automatic logic [BYTE_W-1:0] pack_status(input logic [NCH-1:0] irq_lo,
                                                    input logic [NCH-1:0] sel);
    return {~irq_lo, sel};
  endfunction

endpackage

// File: rtl/i2csw_bitsync.sv
module i2csw_bitsync #(
  parameter int W       = 2,
  parameter int STAGES  = 2,
  parameter logic RST_V = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= {W{RST_V}};
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/i2csw_cond.sv
module i2csw_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign start_evt = scl_q & scl_lvl & sda_q & ~sda_lvl;
  assign stop_evt  = scl_q & scl_lvl & ~sda_q & sda_lvl;
  assign scl_rise  = ~scl_q & scl_lvl;
  assign scl_fall  = scl_q & ~scl_lvl;

  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall})); // R10
endmodule

// File: rtl/i2csw_engine.sv
module i2csw_engine
  import i2csw_pkg::*;
#(
  parameter logic [HI_W-1:0] ADDR_HI = 5'b11100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_lvl,
  input  logic                 sda_lvl,
  input  logic                 start_evt,
  input  logic                 stop_evt,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic [1:0]           strap,
  input  logic [BYTE_W-1:0]    status,
  output logic                 sda_oe,
  output logic                 wr_strobe,
  output logic [NCH-1:0]       wr_sel
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  eng_st_t           st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              done;
  logic              rw;
  logic              hit;
  logic              byte_end;

  assign hit      = addr_hit(sh[BYTE_W-1:1], ADDR_HI, strap);
  assign byte_end = scl_fall & done;
  assign wr_strobe = (st == ST_WDAT) & byte_end;
  assign wr_sel    = sh[NCH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sh     <= '0;
      cnt    <= '0;
      done   <= 1'b0;
      rw     <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      done   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      st     <= ST_IDLE;
      done   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise && !done) begin
            sh  <= {sh[BYTE_W-2:0], sda_lvl};
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) done <= 1'b1;
          end else if (byte_end) begin
            done <= 1'b0;
            cnt  <= '0;
            if (st == ST_ADDR) begin
              if (hit) begin
                sda_oe <= 1'b1;
                rw     <= sh[0];
                st     <= ST_AACK;
              end else begin
                st <= ST_SKIP;
              end
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_WACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw) begin
              sh     <= status;
              sda_oe <= ~status[BYTE_W-1];
              cnt    <= '0;
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WDAT;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sh     <= {sh[BYTE_W-2:0], 1'b0};
              sda_oe <= ~sh[BYTE_W-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) st <= sda_lvl ? ST_SKIP : ST_RNXT;
        end
        ST_RNXT: begin
          if (scl_fall) begin
            sh     <= status;
            sda_oe <= ~status[BYTE_W-1];
            cnt    <= '0;
            st     <= ST_RDAT;
          end
        end
        default: ;
      endcase
    end
  end

  AST_DRIVE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_lvl) |-> ($stable(sda_oe) || !sda_oe)); // R8
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe); // R3
  AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && scl_rise && sda_lvl && !start_evt) |=> (!sda_oe && st == ST_SKIP)); // R9
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR && !sda_oe)); // R10
endmodule

// File: rtl/i2csw_chansel.sv
module i2csw_chansel
  import i2csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              wr_strobe,
  input  logic [NCH-1:0]    wr_sel,
  input  logic [NCH-1:0]    irq_lvl,
  output logic [NCH-1:0]    chan_en,
  output logic [BYTE_W-1:0] status
);
  logic [NCH-1:0] pend;
  logic           pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      pend_v  <= 1'b0;
      chan_en <= '0;
    end else if (start_evt) begin
      pend_v <= 1'b0;
    end else if (stop_evt) begin
      if (pend_v) chan_en <= pend;
      pend_v <= 1'b0;
    end else if (wr_strobe) begin
      pend   <= wr_sel;
      pend_v <= 1'b1;
    end
  end

  assign status = pack_status(irq_lvl, chan_en);

  AST_EN_ONLY_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_en) |-> $past(stop_evt)); // R4
  AST_START_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !pend_v); // R10
endmodule

// File: rtl/i2csw_top.sv
module i2csw_top
  import i2csw_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [HI_W-1:0]  ADDR_HI     = 5'b11100
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           scl_i,
  input  logic           sda_i,
  input  logic [1:0]     strap_a,
  input  logic [NCH-1:0] irq_n,
  output logic           sda_oe,
  output logic [NCH-1:0] chan_en
);
  logic [1:0]        bus_lvl;
  logic [NCH-1:0]    irq_lvl;
  logic              start_evt, stop_evt, scl_rise, scl_fall;
  logic              wr_strobe;
  logic [NCH-1:0]    wr_sel;
  logic [BYTE_W-1:0] status;

  i2csw_bitsync #(.W(2), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_async({scl_i, sda_i}), .q_sync(bus_lvl));

  i2csw_bitsync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_V(1'b1)) u_irq_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_n), .q_sync(irq_lvl));

  i2csw_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_lvl(bus_lvl[1]), .sda_lvl(bus_lvl[0]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  i2csw_engine #(.ADDR_HI(ADDR_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_lvl(bus_lvl[1]), .sda_lvl(bus_lvl[0]),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .strap(strap_a), .status(status),
    .sda_oe(sda_oe), .wr_strobe(wr_strobe), .wr_sel(wr_sel));

  i2csw_chansel u_chansel (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .wr_strobe(wr_strobe), .wr_sel(wr_sel), .irq_lvl(irq_lvl),
    .chan_en(chan_en), .status(status));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (chan_en == '0 && !sda_oe)); // R1
endmodule

// File: tb/i2csw_top_test.sv
module i2csw_top_test;
  localparam int CLK_PER = 10;
  localparam int T       = 8;
  localparam int WDOG    = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic [3:0] irq_n = 4'hF;
  logic       sda_oe;
  logic [3:0] chan_en;
  wire        sda_line = sda_m & ~sda_oe;

  int  vectors = 0;
  int  miss = 0;
  int  cycles = 0;
  bit  finished = 1'b0;
  logic [3:0] exp_en = 4'h0;

  i2csw_top uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_a(strap), .irq_n(irq_n), .sda_oe(sda_oe), .chan_en(chan_en));

  always #(CLK_PER/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG && !finished) begin
      miss++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ph();
    repeat (T) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; ph(); scl_m = 1'b1; ph(); sda_m = 1'b0; ph(); scl_m = 1'b0; ph();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; ph(); scl_m = 1'b1; ph(); sda_m = 1'b1; ph(); ph();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; ph(); scl_m = 1'b1; ph(); ph(); scl_m = 1'b0; ph();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; ph(); scl_m = 1'b1; ph();
    ack = ~sda_line;
    ph(); scl_m = 1'b0; ph();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic steady);
    logic b1, b2;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b1; ph(); b1 = sda_line; ph(); b2 = sda_line;
      scl_m = 1'b0; ph();
      d[i] = b1;
      if (b1 != b2) steady = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; ph();
    scl_m = 1'b1; ph(); ph(); scl_m = 1'b0; ph();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] addr_of(input logic [1:0] a, input logic rd);
    return {5'b11100, a, rd};
  endfunction

  initial begin
    logic       ack;
    logic [7:0] rb;
    logic       steady;

    // R1 reset state
    repeat (5) @(posedge clk); #1;
    chk(chan_en == 4'h0, "R1 chan_en in reset", chan_en, 0);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1; ph();
    chk(chan_en == 4'h0 && !sda_oe, "R1 after release", chan_en, 0);

    // R2 / R3 / R4 / R5: straps x address candidates
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s); ph();
      for (int a = 0; a < 4; a++) begin
        logic [7:0] dv;
        dv = 8'hA0 | 8'((s * 4 + a + 1) % 16);
        bus_start();
        send_byte(addr_of(2'(a), 1'b0), ack);
        chk(ack == (a == s), "R2/R3 address ack", ack, (a == s));
        send_byte(dv, ack);
        if (a == s) begin
          chk(ack == 1'b1, "R4 data ack", ack, 1);
          chk(chan_en == exp_en, "R4 held before STOP", chan_en, exp_en);
          exp_en = dv[3:0];
        end else begin
          chk(ack == 1'b0, "R3 data ignored", ack, 0);
        end
        bus_stop();
        chk(chan_en == exp_en, "R5/R3 after STOP", chan_en, exp_en);
      end
    end

    // R5 / R7 / R8 / R9: every selection with an interrupt pattern, read back
    strap = 2'd2; ph();
    for (int k = 0; k < 16; k++) begin
      logic [3:0] pat;
      pat = 4'((k * 5 + 3) % 16);
      bus_start();
      send_byte(addr_of(2'd2, 1'b0), ack);
      send_byte({4'(15 - k), 4'(k)}, ack);
      bus_stop();
      exp_en = 4'(k);
      chk(chan_en == exp_en, "R5 selection sweep", chan_en, exp_en);
      irq_n = pat; ph();
      bus_start();
      send_byte(addr_of(2'd2, 1'b1), ack);
      chk(ack == 1'b1, "R2 read address ack", ack, 1);
      recv_byte(1'b0, rb, steady);
      chk(rb == {~pat, exp_en}, "R7 status byte", rb, {~pat, exp_en});
      chk(steady, "R8 SDA steady while SCL high", steady, 1);
      sda_m = 1'b1; ph(); scl_m = 1'b1; ph();
      chk(sda_line == 1'b1, "R9 released after NACK", sda_line, 1);
      ph(); scl_m = 1'b0; ph();
      bus_stop();
      chk(chan_en == exp_en, "R7 read leaves selection", chan_en, exp_en);
    end

    // R7 multi-byte read with master ACK
    irq_n = 4'b0110; ph();
    bus_start();
    send_byte(addr_of(2'd2, 1'b1), ack);
    recv_byte(1'b1, rb, steady);
    chk(rb == {4'b1001, exp_en}, "R7 first of two", rb, {4'b1001, exp_en});
    recv_byte(1'b0, rb, steady);
    chk(rb == {4'b1001, exp_en}, "R7 second of two", rb, {4'b1001, exp_en});
    bus_stop();

    // R6 last byte wins
    bus_start();
    send_byte(addr_of(2'd2, 1'b0), ack);
    send_byte(8'h03, ack);
    chk(ack, "R6 byte1 ack", ack, 1);
    send_byte(8'h09, ack);
    chk(ack, "R6 byte2 ack", ack, 1);
    send_byte(8'h56, ack);
    chk(ack, "R6 byte3 ack", ack, 1);
    bus_stop();
    exp_en = 4'h6;
    chk(chan_en == exp_en, "R6 last byte applied", chan_en, exp_en);

    // R10 repeated START discards pending write
    bus_start();
    send_byte(addr_of(2'd2, 1'b0), ack);
    send_byte(8'h0B, ack);
    bus_start();
    send_byte(addr_of(2'd2, 1'b1), ack);
    chk(ack, "R10 restart address ack", ack, 1);
    recv_byte(1'b0, rb, steady);
    chk(rb[3:0] == exp_en, "R10 read shows old selection", rb[3:0], exp_en);
    bus_stop();
    chk(chan_en == exp_en, "R10 pending discarded", chan_en, exp_en);

    // R10 repeated START inside a byte
    bus_start();
    send_byte(addr_of(2'd2, 1'b0), ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(addr_of(2'd2, 1'b0), ack);
    chk(ack, "R10 address after mid-byte START", ack, 1);
    send_byte(8'h09, ack);
    bus_stop();
    exp_en = 4'h9;
    chk(chan_en == exp_en, "R10 new transfer applied", chan_en, exp_en);

    // R1 reset in the middle of a transfer
    bus_start();
    send_byte(addr_of(2'd2, 1'b0), ack);
    send_bit(1'b0); send_bit(1'b1);
    rst_n = 1'b0; ph();
    chk(chan_en == 4'h0 && !sda_oe, "R1 mid-transfer reset", chan_en, 0);
    rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1; ph(); ph();
    bus_stop();
    chk(chan_en == 4'h0, "R1 stays cleared after reset", chan_en, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule